// File: doc/BRIEF.md
# Converter Bus Bridge with Wait States

This block is a slave on a synchronous system bus. It places two 16-bit analog-to-digital converters, a two-channel digital-to-analog converter, a converter status register and a clear-control register in one address window. The top two address bits pick a region: 0 is the registers, 1 is the first ADC, 2 is the second ADC, and 3 is the DAC. The block decodes each request. It then drives a simple parallel strobe interface toward the converters: one chip select per device, read and write enables, a DAC channel select, and 16-bit data buses.

A master raises `busSel` with a stable address, direction and write data, and keeps them stable until `busReady` is high. The master may start a new request in the very next cycle.

A device access takes a fixed four cycles. If a new device request arrives in the cycle right after a device access completes, that access first waits three extra cycles. Register accesses and all other accesses finish in the cycle they are presented. The clear-control register drives the DAC's active-low clear line. The DAC's load input is held active, so every written value takes effect at once.

Top module: `conv_bus_bridge`

## Requirements
- R1: A read at offset 0x000000 returns the first ADC busy input in bit 0 and the second in bit 1. All other bits read zero.
- R2: The clear-control register sits at offset 0x000004 and resets to 0, so `dacClearN` is low after reset. A write stores `busWdata[0]` and drives it on `dacClearN` from the next cycle. A read returns the stored bit in bit 0.
- R3: A read at 0x100000 asserts `devCs[0]` and a read at 0x200000 asserts `devCs[1]`, each together with `devRdEn`. The value on `devRdata` is returned on `busRdata`. At most one chip select is high at any time.
- R4: A write at 0x300000 asserts `devCs[2]` and `devWrEn` with `devChan` = 0 (channel A). A write at 0x300004 does the same with `devChan` = 1 (channel B). `devWdata` carries the written value.
- R5: An isolated device access gives `busReady` in the 4th cycle of the request. The chip select and enable are high in cycles 1 to 3 only.
- R6: A device request presented in the cycle right after a device access gives `busReady` in its 7th cycle. Its strobes are high in cycles 4 to 6 only.
- R7: One idle bus cycle between device accesses cancels the three-cycle penalty.
- R8: Register accesses, unmapped accesses, DAC reads and ADC writes give `busReady` in their first cycle and assert no chip select.
- R9: Reads of unmapped offsets and of DAC locations return zero. Writes to ADC locations, the status register or unmapped offsets change nothing, including the clear-control register.
- R10: ADC read data is captured from `devRdata` in the last strobe cycle. A change of `devRdata` in the ready cycle does not affect `busRdata`.
- R11: `dacLoadN` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Request valid, held until ready |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 22 | Byte offset inside the window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid with busReady |
| busReady | output | 1 | Access completes this cycle |
| devCs | output | 3 | Chip selects: ADC 1, ADC 2, DAC |
| devRdEn | output | 1 | Device read enable |
| devWrEn | output | 1 | Device write enable |
| devChan | output | 1 | DAC channel select (0 = A, 1 = B) |
| devWdata | output | 16 | Data to the DAC |
| devRdata | input | 16 | Data from the selected ADC |
| adcBusy | input | 2 | Busy flags of the two ADCs |
| dacClearN | output | 1 | Active-low DAC clear |
| dacLoadN | output | 1 | Active-low DAC load, tied active |

## Verification
Register and unmapped accesses are due in the same cycle they are presented. An isolated device access is due in the fourth cycle of the request, and a back-to-back one in the seventh. A write to the clear-control register shows on `dacClearN` one cycle later.

The bench drives inputs just after the falling edge and samples 1 ns later. It counts request cycles from the first cycle `busSel` is high and records the strobes in every cycle. It compares the cycle in which ready appears against the latency computed for that access. In the ready cycle it also drives a changed `devRdata`, to show that the data was captured one cycle earlier.

// File: rtl/conv_bridge_pkg.sv
package conv_bridge_pkg;

  typedef enum logic [2:0] {
    TGT_STATUS,
    TGT_CLEAR,
    TGT_ADC0,
    TGT_ADC1,
    TGT_DAC_A,
    TGT_DAC_B,
    TGT_NONE
  } target_t;

  typedef struct packed {
    logic [2:0] devSel;
    logic       rdStb;
    logic       wrStb;
    logic       capture;
    logic       clrWrite;
    logic       regReady;
    logic       devReady;
  } ctlStrobes_t;

endpackage

// File: rtl/conv_addr_decode.sv
module conv_addr_decode
  import conv_bridge_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output target_t           target
);
  localparam int OFS_W = ADDR_W - 2;

  logic [1:0]       region;
  logic [OFS_W-1:0] offset;
  logic             atFirst;
  logic             atSecond;

  assign region   = addr[ADDR_W-1 -: 2];
  assign offset   = addr[OFS_W-1:0];
  assign atFirst  = (offset == OFS_W'(0));
  assign atSecond = (offset == OFS_W'(4));

  always_comb begin
    target = TGT_NONE;
    unique case (region)
      2'd0: if (atFirst) target = TGT_STATUS;
            else if (atSecond) target = TGT_CLEAR;
      2'd1: if (atFirst) target = TGT_ADC0;
      2'd2: if (atFirst) target = TGT_ADC1;
      default: if (atFirst) target = TGT_DAC_A;
               else if (atSecond) target = TGT_DAC_B;
    endcase
  end
endmodule

// File: rtl/conv_bridge_ctrl.sv
module conv_bridge_ctrl
  import conv_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4,
  parameter int B2B_WAIT      = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  target_t     target,
  output ctlStrobes_t ctl
);
  localparam int CW = $clog2(ACCESS_CYCLES + B2B_WAIT + 1);
  localparam logic [CW-1:0] LAST_PLAIN = CW'(ACCESS_CYCLES - 1);
  localparam logic [CW-1:0] LAST_PEN   = CW'(ACCESS_CYCLES + B2B_WAIT - 1);
  localparam logic [CW-1:0] OFF_PEN    = CW'(B2B_WAIT);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          penReg;
  logic          prevDone;

  logic          isAdcRd;
  logic          isDacWr;
  logic          devReq;
  logic          active;
  logic          penNow;
  logic [CW-1:0] kNow;
  logic [CW-1:0] offNow;
  logic [CW-1:0] lastNow;
  logic          inWin;

  assign isAdcRd = !busWrite && (target == TGT_ADC0 || target == TGT_ADC1);
  assign isDacWr = busWrite && (target == TGT_DAC_A || target == TGT_DAC_B);
  assign devReq  = busSel && (isAdcRd || isDacWr);
  assign active  = busy || devReq;
  assign kNow    = busy ? cnt : '0;
  assign penNow  = busy ? penReg : prevDone;
  assign offNow  = penNow ? OFF_PEN : '0;
  assign lastNow = penNow ? LAST_PEN : LAST_PLAIN;
  assign inWin   = active && (kNow >= offNow) && (kNow < lastNow);

  always_comb begin
    ctl          = '0;
    ctl.devSel   = {inWin && (target == TGT_DAC_A || target == TGT_DAC_B),
                    inWin && (target == TGT_ADC1),
                    inWin && (target == TGT_ADC0)};
    ctl.rdStb    = inWin && !busWrite;
    ctl.wrStb    = inWin && busWrite;
    ctl.capture  = inWin && !busWrite && (kNow == lastNow - CW'(1));
    ctl.devReady = active && (kNow == lastNow);
    ctl.regReady = busSel && !busy && !devReq;
    ctl.clrWrite = ctl.regReady && busWrite && (target == TGT_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      penReg   <= 1'b0;
      prevDone <= 1'b0;
    end else begin
      prevDone <= ctl.devReady;
      if (ctl.devReady) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (active) begin
        busy <= 1'b1;
        cnt  <= kNow + CW'(1);
        if (!busy) penReg <= prevDone;
      end
    end
  end

  // R3: device selects never overlap
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.devSel));

  // R5: a device completion always follows a strobed cycle
  assert_ready_after_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.devReady |-> $past(ctl.rdStb || ctl.wrStb));

  // R6: back-to-back request starts with a quiet wait, no select
  assert_penalty_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (prevDone && devReq && !busy) |-> (ctl.devSel == 3'b000));

  // R5: master holds the request while a device access runs
  assert_busy_holds_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busSel);
endmodule

// File: rtl/conv_bridge_dp.sv
module conv_bridge_dp
  import conv_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_ADC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  target_t            target,
  input  logic               busWrite,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [DATA_W-1:0]  devRdata,
  input  logic [NUM_ADC-1:0] adcBusy,
  output logic [DATA_W-1:0]  busRdata,
  output logic [2:0]         devCs,
  output logic               devRdEn,
  output logic               devWrEn,
  output logic               devChan,
  output logic [DATA_W-1:0]  devWdata,
  output logic               dacClearN
);
  logic [DATA_W-1:0] capReg;
  logic              clrReg;
  logic [DATA_W-1:0] regRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg <= '0;
      clrReg <= 1'b0;
    end else begin
      if (ctl.capture)  capReg <= devRdata;
      if (ctl.clrWrite) clrReg <= busWdata[0];
    end
  end

  always_comb begin
    regRead = '0;
    if (target == TGT_STATUS)     regRead[NUM_ADC-1:0] = adcBusy;
    else if (target == TGT_CLEAR) regRead[0] = clrReg;
  end

  always_comb begin
    busRdata = '0;
    if (ctl.devReady && !busWrite)      busRdata = capReg;
    else if (ctl.regReady && !busWrite) busRdata = regRead;
  end

  assign devCs     = ctl.devSel;
  assign devRdEn   = ctl.rdStb;
  assign devWrEn   = ctl.wrStb;
  assign devChan   = (target == TGT_DAC_B);
  assign devWdata  = busWdata;
  assign dacClearN = clrReg;

  // R2: clear line follows the written bit one cycle later
  assert_clear_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWrite |=> (dacClearN == $past(busWdata[0])));

  // R10: read data returned is the value seen on the capture cycle
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (busRdata == $past(devRdata)));
endmodule

// File: rtl/conv_bus_bridge.sv
module conv_bus_bridge
  import conv_bridge_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int ACCESS_CYCLES = 4,
  parameter int B2B_WAIT      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic [2:0]        devCs,
  output logic              devRdEn,
  output logic              devWrEn,
  output logic              devChan,
  output logic [DATA_W-1:0] devWdata,
  input  logic [DATA_W-1:0] devRdata,
  input  logic [1:0]        adcBusy,
  output logic              dacClearN,
  output logic              dacLoadN
);
  target_t     target;
  ctlStrobes_t ctl;

  conv_addr_decode #(.ADDR_W(ADDR_W)) uDecode (
    .addr   (busAddr),
    .target (target)
  );

  conv_bridge_ctrl #(
    .ACCESS_CYCLES (ACCESS_CYCLES),
    .B2B_WAIT      (B2B_WAIT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .target   (target),
    .ctl      (ctl)
  );

  conv_bridge_dp #(.DATA_W(DATA_W), .NUM_ADC(2)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .target    (target),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .devRdata  (devRdata),
    .adcBusy   (adcBusy),
    .busRdata  (busRdata),
    .devCs     (devCs),
    .devRdEn   (devRdEn),
    .devWrEn   (devWrEn),
    .devChan   (devChan),
    .devWdata  (devWdata),
    .dacClearN (dacClearN)
  );

  assign busReady = ctl.regReady || ctl.devReady;
  assign dacLoadN = 1'b0; // R11: load strobe permanently active
endmodule

// File: tb/tb_conv_bus_bridge.sv
module tb_conv_bus_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [21:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busReady;
  logic [2:0]  devCs;
  logic        devRdEn;
  logic        devWrEn;
  logic        devChan;
  logic [15:0] devWdata;
  logic [15:0] devRdata = '0;
  logic [1:0]  adcBusy = '0;
  logic        dacClearN;
  logic        dacLoadN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  conv_bus_bridge dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .devCs(devCs), .devRdEn(devRdEn), .devWrEn(devWrEn),
    .devChan(devChan), .devWdata(devWdata), .devRdata(devRdata),
    .adcBusy(adcBusy), .dacClearN(dacClearN), .dacLoadN(dacLoadN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus access; expCs = -1 means no device strobe expected.
  task automatic access(input bit wr, input logic [21:0] a, input logic [15:0] wd,
                        input logic [15:0] devVal, input int expLat, input int expCs,
                        input bit expChan, input bit chkRd, input logic [15:0] expRd,
                        input string req);
    int lat = 0;
    int bad = 0;
    int badAct = 0;
    int badExp = 0;
    logic [15:0] rd = '0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = wd;
      devRdata = (k == expLat) ? ~devVal : devVal;
      #1;
      begin
        logic [2:0] eCs;
        bit inW;
        inW = (expCs >= 0) && (k >= expLat - 3) && (k <= expLat - 1);
        eCs = inW ? 3'(1 << expCs) : 3'b000;
        if (devCs !== eCs || devRdEn !== (inW && !wr) || devWrEn !== (inW && wr) ||
            (inW && wr && (devChan !== expChan || devWdata !== wd))) begin
          if (bad == 0) begin badAct = {devRdEn, devWrEn, devCs}; badExp = {inW && !wr, inW && wr, eCs}; end
          bad++;
        end
      end
      if (busReady === 1'b1) begin lat = k; rd = busRdata; break; end
    end
    check(lat == expLat, req, "ready cycle", lat, expLat);
    check(bad == 0, req, "strobes {rd,wr,cs}", badAct, badExp);
    if (chkRd) check(rd === expRd, req, "read data", rd, expRd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); busSel = 1'b0; busWrite = 1'b0;
    end
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    check(dacClearN === 1'b0, "R2", "clear after reset", dacClearN, 0);
    check(devCs === 3'b000 && busReady === 1'b0, "R8", "idle outputs", {busReady, devCs}, 0);
    check(dacLoadN === 1'b0, "R11", "load strobe", dacLoadN, 0);
  endtask

  task automatic testStatus();
    adcBusy = 2'b01;
    access(0, 22'h000000, 0, 0, 1, -1, 0, 1, 16'h0001, "R1");
    idle(1);
    adcBusy = 2'b10;
    access(0, 22'h000000, 0, 0, 1, -1, 0, 1, 16'h0002, "R1");
    idle(1);
    adcBusy = 2'b00;
  endtask

  task automatic testClear();
    access(0, 22'h000004, 0, 0, 1, -1, 0, 1, 16'h0000, "R2");
    access(1, 22'h000004, 16'hFFFF, 0, 1, -1, 0, 0, 0, "R2");
    idle(1); #1;
    check(dacClearN === 1'b1, "R2", "clear line released", dacClearN, 1);
    access(0, 22'h000004, 0, 0, 1, -1, 0, 1, 16'h0001, "R2");
    idle(1);
  endtask

  task automatic testAdc();
    access(0, 22'h100000, 0, 16'hA5C3, 4, 0, 0, 1, 16'hA5C3, "R3 R5 R10");
    idle(1);
    access(0, 22'h200000, 0, 16'h1234, 4, 1, 0, 1, 16'h1234, "R3 R5 R10");
    idle(1);
  endtask

  task automatic testDac();
    access(1, 22'h300000, 16'h0ABC, 0, 4, 2, 0, 0, 0, "R4");
    idle(1);
    access(1, 22'h300004, 16'h0DEF, 0, 4, 2, 1, 0, 0, "R4");
    idle(1);
  endtask

  task automatic testBackToBack();
    access(1, 22'h300000, 16'h0111, 0, 4, 2, 0, 0, 0, "R6");
    access(0, 22'h100000, 0, 16'h7E57, 7, 0, 0, 1, 16'h7E57, "R6");
    access(1, 22'h300004, 16'h0222, 0, 7, 2, 1, 0, 0, "R6");
    idle(1);
  endtask

  task automatic testIdleCancels();
    access(0, 22'h200000, 0, 16'h4321, 4, 1, 0, 1, 16'h4321, "R7");
    idle(1);
    access(0, 22'h200000, 0, 16'h5678, 4, 1, 0, 1, 16'h5678, "R7");
    access(0, 22'h000000, 0, 0, 1, -1, 0, 1, 16'h0000, "R8");
    access(0, 22'h100000, 0, 16'h9999, 4, 0, 0, 1, 16'h9999, "R7");
    idle(1);
  endtask

  task automatic testIgnored();
    access(0, 22'h300000, 0, 16'hFFFF, 1, -1, 0, 1, 16'h0000, "R9");
    access(0, 22'h000008, 0, 16'hFFFF, 1, -1, 0, 1, 16'h0000, "R9");
    access(0, 22'h100004, 0, 16'hFFFF, 1, -1, 0, 1, 16'h0000, "R9");
    access(1, 22'h100000, 16'h0000, 0, 1, -1, 0, 0, 0, "R9 R8");
    access(1, 22'h000000, 16'h0000, 0, 1, -1, 0, 0, 0, "R9");
    access(1, 22'h000010, 16'h0000, 0, 1, -1, 0, 0, 0, "R9");
    idle(1); #1;
    check(dacClearN === 1'b1, "R9", "clear line untouched", dacClearN, 1);
    access(1, 22'h000004, 16'h0000, 0, 1, -1, 0, 0, 0, "R2");
    idle(1); #1;
    check(dacClearN === 1'b0, "R2", "clear line asserted", dacClearN, 0);
    check(dacLoadN === 1'b0, "R11", "load strobe", dacLoadN, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStatus();
    testClear();
    testAdc();
    testDac();
    testBackToBack();
    testIdleCancels();
    testIgnored();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule